// File: doc/BRIEF.md
# Module Geometry to Row-Boundary Decoder

This block turns the presence-detect bytes of two memory module sockets into the values a memory controller needs for address decode. After a one-cycle `start` pulse it fetches seven bytes per socket through a request/response byte interface. For each socket it works out the two side sizes and checks the module against the supported limits. It then produces cumulative row boundaries in 32 MB units, with the topmost boundary copied into two extra entries, and one attribute code per socket that encodes page size and bank count. A module that breaks a rule raises a sticky `fatal` flag, and that module is left out of the map.

The byte source sits behind two valid/ready channels. On the request channel the block holds `rq_valid` with a stable `rq_socket`/`rq_field` until `rq_ready` is seen high at a clock edge; the source may hold `rq_ready` low for any number of cycles. After that handshake the block raises `rsp_ready` and keeps it high until the source presents `rsp_valid` with the byte. The source may delay `rsp_valid` for any number of cycles. Only one request is outstanding at a time, and `rsp_valid` is ignored while `rsp_ready` is low. Field codes on `rq_field`: 0 memory type, 1 density bitmask, 2 bank count, 3 cycle time, 4 access time, 5 column address bits, 6 data width.

Top module: `spd_geom_decoder`

## Requirements
- R1: After reset, and in the cycle after an accepted `start`, `done` and `fatal` are 0, every boundary entry is 0 and every attribute code is 0xFF.
- R2: Socket 0 is fetched before socket 1, and within a socket the fields are requested in code order 0 to 6. A socket whose type byte is not 4 gets only field 0 requested. `rq_valid` holds with stable socket and field until `rq_ready`, and `rsp_ready` is never high while `rq_valid` is.
- R3: A socket is present only when its type byte equals 4. An absent socket adds 0 to both of its rows and gets attribute 0xFF, and it is not fatal.
- R4: Side-1 size in MB is 4 times the value of the highest set bit of the density byte. When the bank byte is greater than 1 and the density byte has exactly one bit set, side 2 equals side 1. In every other case side 2 is 0, which folds an asymmetric module back to single-sided.
- R5: A present module whose side-1 size is below 32 MB or above 256 MB, whose cycle-time byte is not 0x75, or whose access-time byte is not 0x54 is fatal.
- R6: Boundary entry i occupies `bound_o[8i+7:8i]`. With sizes in 32 MB units, entry 0 = s0 side1, entry 1 = entry 0 + s0 side2, entry 2 = entry 1 + s1 side1, entry 3 = entry 2 + s1 side2. Entries 4 and 5 both equal entry 3.
- R7: Page size in KB is floor(width × 2^columns / 8192). Only 2, 4, 8 and 16 KB are allowed, and any other result is fatal.
- R8: Socket s's code occupies `attr_o[8s+7:8s]`. For page sizes 2/4/8/16 KB the code is 0xF0/0xF1/0xF2/0xF3 with a bank byte of 1, and 0x00/0x11/0x22/0x33 with a bank byte of 2. Any other bank byte is fatal.
- R9: A fatal socket adds 0 to its rows and gets attribute 0xFF, and the other socket is still decoded. `fatal` stays high until the next accepted `start`.
- R10: `done` rises once both sockets are decoded. Outputs then hold until the next `start`, and a `start` pulse while a decode is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a decode when idle |
| rq_valid | output | 1 | Byte request pending |
| rq_ready | input | 1 | Source accepts the request |
| rq_socket | output | 1 | Socket index of the request |
| rq_field | output | 3 | Field code of the request |
| rsp_valid | input | 1 | Requested byte is present |
| rsp_ready | output | 1 | Block waits for the response byte |
| rsp_data | input | 8 | Response byte |
| done | output | 1 | Both sockets decoded, outputs valid |
| fatal | output | 1 | A present module broke a supported rule |
| bound_o | output | 48 | Six 8-bit boundary entries, entry 0 in the low byte |
| attr_o | output | 16 | Two 8-bit attribute codes, socket 0 in the low byte |

## Verification
A corrupted capture register or a wrong field counter shows at the ports within a single decode. It either changes the order of `rq_field` values, which is visible the cycle after the faulty handshake, or it changes a boundary entry or attribute code by the time `done` rises. A corrupted per-socket result register also breaks the cumulative chain, so every later boundary entry and both top copies go wrong together. A fatal flag that drops early or a result that moves after `done` is seen in the next cycle. The sweeps cover every density byte under both bank counts, with timing-byte faults and absent sockets mixed in, and a grid of column counts and widths around the page-size limits.

// File: rtl/spd_geom_pkg.sv
package spd_geom_pkg;

  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 3;

  typedef enum logic [FIELD_W-1:0] {
    FLD_TYPE    = 3'd0,
    FLD_DENSITY = 3'd1,
    FLD_BANKS   = 3'd2,
    FLD_CYCLE   = 3'd3,
    FLD_ACCESS  = 3'd4,
    FLD_COLS    = 3'd5,
    FLD_WIDTH   = 3'd6
  } spd_field_e;

  typedef struct packed {
    logic [BYTE_W-1:0] mtype;
    logic [BYTE_W-1:0] density;
    logic [BYTE_W-1:0] banks;
    logic [BYTE_W-1:0] cycle;
    logic [BYTE_W-1:0] access;
    logic [BYTE_W-1:0] cols;
    logic [BYTE_W-1:0] width;
  } spd_bytes_t;

  typedef struct packed {
    logic [BYTE_W-1:0] side_a;
    logic [BYTE_W-1:0] side_b;
    logic [BYTE_W-1:0] attr;
    logic              fatal;
  } sock_result_t;

  localparam logic [BYTE_W-1:0] TYPE_PRESENT = 8'h04;
  localparam logic [BYTE_W-1:0] CYCLE_OK     = 8'h75;
  localparam logic [BYTE_W-1:0] ACCESS_OK    = 8'h54;
  localparam logic [BYTE_W-1:0] ATTR_EMPTY   = 8'hFF;

  function automatic logic attr_is_legal(input logic [BYTE_W-1:0] c);
    return (c == ATTR_EMPTY) ||
           (c[7:2] == 6'b111100) ||
           (c[7:6] == 2'b00 && c[3:2] == 2'b00 && c[5:4] == c[1:0]);
  endfunction

endpackage

// File: rtl/spd_geom_seq.sv
module spd_geom_seq
  import spd_geom_pkg::*;
#(
  parameter int NUM_SOCK = 2,
  localparam int SOCK_W = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               rq_valid,
  input  logic               rq_ready,
  output logic [SOCK_W-1:0]  rq_socket,
  output logic [FIELD_W-1:0] rq_field,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [BYTE_W-1:0]  rsp_data,
  output spd_bytes_t         bytes_q,
  output logic               eval_o,
  output logic [SOCK_W-1:0]  eval_sock,
  output logic               clear_o,
  output logic               done_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_EVAL} st_e;

  localparam logic [SOCK_W-1:0] LAST_SOCK = SOCK_W'(NUM_SOCK - 1);

  st_e               state_q;
  spd_field_e        field_q;
  logic [SOCK_W-1:0] sock_q;
  logic              done_q;
  logic              last_field;

  // A socket ends early when its type byte says nothing is fitted.
  assign last_field = (field_q == FLD_WIDTH) ||
                      (field_q == FLD_TYPE && rsp_data != TYPE_PRESENT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      field_q <= FLD_TYPE;
      sock_q  <= '0;
      done_q  <= 1'b0;
      bytes_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            sock_q  <= '0;
            field_q <= FLD_TYPE;
            done_q  <= 1'b0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rq_ready) state_q <= ST_RSP;
        end
        ST_RSP: begin
          if (rsp_valid) begin
            unique case (field_q)
              FLD_TYPE:    bytes_q.mtype   <= rsp_data;
              FLD_DENSITY: bytes_q.density <= rsp_data;
              FLD_BANKS:   bytes_q.banks   <= rsp_data;
              FLD_CYCLE:   bytes_q.cycle   <= rsp_data;
              FLD_ACCESS:  bytes_q.access  <= rsp_data;
              FLD_COLS:    bytes_q.cols    <= rsp_data;
              default:     bytes_q.width   <= rsp_data;
            endcase
            if (last_field) begin
              state_q <= ST_EVAL;
            end else begin
              field_q <= spd_field_e'(field_q + 3'd1);
              state_q <= ST_REQ;
            end
          end
        end
        default: begin
          if (sock_q == LAST_SOCK) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            sock_q  <= sock_q + 1'b1;
            field_q <= FLD_TYPE;
            state_q <= ST_REQ;
          end
        end
      endcase
    end
  end

  assign rq_valid  = (state_q == ST_REQ);
  assign rsp_ready = (state_q == ST_RSP);
  assign rq_socket = sock_q;
  assign rq_field  = field_q;
  assign eval_o    = (state_q == ST_EVAL);
  assign eval_sock = sock_q;
  assign clear_o   = (state_q == ST_IDLE) && start;
  assign done_o    = done_q;

endmodule

// File: rtl/spd_sock_eval.sv
module spd_sock_eval
  import spd_geom_pkg::*;
(
  input  spd_bytes_t   bytes_i,
  output sock_result_t res_o
);

  logic              present;
  logic [2:0]        top_bit;
  logic              dens_nz;
  logic              single_bit;
  logic              size_ok;
  logic              timing_ok;
  logic              banks_ok;
  logic              page_ok;
  logic              cols_big;
  logic [24:0]       page_bits;
  logic [11:0]       page_kb;
  logic [1:0]        page_idx;
  logic [BYTE_W-1:0] unit_a;
  logic [BYTE_W-1:0] unit_b;
  logic [BYTE_W-1:0] code;
  logic              bad;

  always_comb begin
    present = (bytes_i.mtype == TYPE_PRESENT);

    // Highest set density bit gives the larger side.
    top_bit = 3'd0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (bytes_i.density[i]) top_bit = 3'(i);
    end
    dens_nz    = |bytes_i.density;
    single_bit = dens_nz &&
                 ((bytes_i.density & (bytes_i.density - 8'd1)) == 8'd0);

    // 4 MB per density unit; 32..256 MB means bit positions 3..6.
    size_ok = dens_nz && (top_bit >= 3'd3) && (top_bit <= 3'd6);
    unit_a  = size_ok ? (8'd1 << (top_bit - 3'd3)) : 8'd0;
    // Second side only for a symmetric multi-bank module.
    unit_b  = ((bytes_i.banks > 8'd1) && single_bit) ? unit_a : 8'd0;

    timing_ok = (bytes_i.cycle == CYCLE_OK) && (bytes_i.access == ACCESS_OK);

    // Page KB = width * 2^cols / 8192; 18+ columns overshoot 16 KB.
    cols_big  = (bytes_i.cols > 8'd17);
    page_bits = {17'd0, bytes_i.width} << bytes_i.cols[4:0];
    page_kb   = page_bits[24:13];
    page_ok   = !cols_big;
    page_idx  = 2'd0;
    unique case (page_kb)
      12'd2:   page_idx = 2'd0;
      12'd4:   page_idx = 2'd1;
      12'd8:   page_idx = 2'd2;
      12'd16:  page_idx = 2'd3;
      default: page_ok  = 1'b0;
    endcase

    banks_ok = 1'b1;
    code     = ATTR_EMPTY;
    if (bytes_i.banks == 8'd1)      code = {6'b111100, page_idx};
    else if (bytes_i.banks == 8'd2) code = {2'b00, page_idx, 2'b00, page_idx};
    else                            banks_ok = 1'b0;

    bad = present && !(size_ok && timing_ok && page_ok && banks_ok);

    if (!present || bad) begin
      res_o.side_a = 8'd0;
      res_o.side_b = 8'd0;
      res_o.attr   = ATTR_EMPTY;
    end else begin
      res_o.side_a = unit_a;
      res_o.side_b = unit_b;
      res_o.attr   = code;
    end
    res_o.fatal = bad;
  end

endmodule

// File: rtl/spd_bound_accum.sv
module spd_bound_accum
  import spd_geom_pkg::*;
#(
  parameter int NUM_SOCK = 2,
  parameter int BW       = 8,
  localparam int SOCK_W  = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1,
  localparam int NUM_ROW = 2 * NUM_SOCK,
  localparam int NUM_ENT = NUM_ROW + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       wr,
  input  logic [SOCK_W-1:0]          wr_sock,
  input  sock_result_t               res,
  output logic [NUM_ENT*BW-1:0]      bound_o,
  output logic [NUM_SOCK*BYTE_W-1:0] attr_o
);

  logic [NUM_SOCK*BW-1:0] side_a_flat;
  logic [NUM_SOCK*BW-1:0] side_b_flat;

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    logic [BW-1:0]     a_q;
    logic [BW-1:0]     b_q;
    logic [BYTE_W-1:0] attr_q;

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        a_q    <= '0;
        b_q    <= '0;
        attr_q <= ATTR_EMPTY;
      end else if (wr && wr_sock == SOCK_W'(s)) begin
        a_q    <= BW'(res.side_a);
        b_q    <= BW'(res.side_b);
        attr_q <= res.attr;
      end
    end

    assign side_a_flat[s*BW +: BW]      = a_q;
    assign side_b_flat[s*BW +: BW]      = b_q;
    assign attr_o[s*BYTE_W +: BYTE_W]   = attr_q;
  end

  // Running sum across rows; the top value fills the two spare entries.
  always_comb begin
    logic [BW-1:0] run;
    run     = '0;
    bound_o = '0;
    for (int s = 0; s < NUM_SOCK; s++) begin
      run = run + side_a_flat[s*BW +: BW];
      bound_o[(2*s)*BW +: BW] = run;
      run = run + side_b_flat[s*BW +: BW];
      bound_o[(2*s+1)*BW +: BW] = run;
    end
    bound_o[NUM_ROW*BW +: BW]     = run;
    bound_o[(NUM_ROW+1)*BW +: BW] = run;
  end

endmodule

// File: rtl/spd_geom_decoder.sv
module spd_geom_decoder
  import spd_geom_pkg::*;
#(
  parameter int NUM_SOCK = 2,
  parameter int BW       = 8,
  localparam int SOCK_W  = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1,
  localparam int NUM_ENT = 2 * NUM_SOCK + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  output logic                       rq_valid,
  input  logic                       rq_ready,
  output logic [SOCK_W-1:0]          rq_socket,
  output logic [FIELD_W-1:0]         rq_field,
  input  logic                       rsp_valid,
  output logic                       rsp_ready,
  input  logic [BYTE_W-1:0]          rsp_data,
  output logic                       done,
  output logic                       fatal,
  output logic [NUM_ENT*BW-1:0]      bound_o,
  output logic [NUM_SOCK*BYTE_W-1:0] attr_o
);

  spd_bytes_t        bytes_q;
  sock_result_t      res;
  logic              eval_en;
  logic [SOCK_W-1:0] eval_sock;
  logic              clear;
  logic              fatal_q;

  spd_geom_seq #(.NUM_SOCK(NUM_SOCK)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rq_valid  (rq_valid),
    .rq_ready  (rq_ready),
    .rq_socket (rq_socket),
    .rq_field  (rq_field),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .bytes_q   (bytes_q),
    .eval_o    (eval_en),
    .eval_sock (eval_sock),
    .clear_o   (clear),
    .done_o    (done)
  );

  spd_sock_eval u_eval (
    .bytes_i (bytes_q),
    .res_o   (res)
  );

  spd_bound_accum #(.NUM_SOCK(NUM_SOCK), .BW(BW)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .wr      (eval_en),
    .wr_sock (eval_sock),
    .res     (res),
    .bound_o (bound_o),
    .attr_o  (attr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clear) fatal_q <= 1'b0;
    else if (eval_en && res.fatal) fatal_q <= 1'b1;
  end

  assign fatal = fatal_q;

endmodule

// File: rtl/spd_geom_checker.sv
module spd_geom_checker
  import spd_geom_pkg::*;
#(
  parameter int NUM_SOCK = 2,
  parameter int BW       = 8,
  localparam int SOCK_W  = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1,
  localparam int NUM_ROW = 2 * NUM_SOCK,
  localparam int NUM_ENT = NUM_ROW + 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       rq_valid,
  input logic                       rq_ready,
  input logic [SOCK_W-1:0]          rq_socket,
  input logic [FIELD_W-1:0]         rq_field,
  input logic                       rsp_ready,
  input logic                       done,
  input logic                       fatal,
  input logic [NUM_ENT*BW-1:0]      bound_o,
  input logic [NUM_SOCK*BYTE_W-1:0] attr_o
);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_socket) && $stable(rq_field));

  assert_one_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> !rsp_ready);

  assert_top_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bound_o[NUM_ROW*BW +: BW] == bound_o[(NUM_ROW-1)*BW +: BW]) &&
             (bound_o[(NUM_ROW+1)*BW +: BW] == bound_o[(NUM_ROW-1)*BW +: BW]));

  for (genvar r = 1; r < NUM_ROW; r++) begin : g_mono
    assert_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> bound_o[r*BW +: BW] >= bound_o[(r-1)*BW +: BW]);
  end

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_attr
    assert_attr_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      attr_is_legal(attr_o[s*BYTE_W +: BYTE_W]));
  end

  assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal && !start |=> fatal);

  assert_hold_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(bound_o) && $stable(attr_o) && $stable(fatal));

  assert_busy_not_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid || rsp_ready) |-> !done);

endmodule

bind spd_geom_decoder spd_geom_checker #(.NUM_SOCK(NUM_SOCK), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rq_valid  (rq_valid),
  .rq_ready  (rq_ready),
  .rq_socket (rq_socket),
  .rq_field  (rq_field),
  .rsp_ready (rsp_ready),
  .done      (done),
  .fatal     (fatal),
  .bound_o   (bound_o),
  .attr_o    (attr_o)
);

// File: tb/tb_spd_geom_decoder.sv
module tb_spd_geom_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rq_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'd0;
  logic        rq_valid;
  logic [0:0]  rq_socket;
  logic [2:0]  rq_field;
  logic        rsp_ready;
  logic        done;
  logic        fatal;
  logic [47:0] bound_o;
  logic [15:0] attr_o;

  always #5ns clk = ~clk;

  spd_geom_decoder dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_socket(rq_socket), .rq_field(rq_field),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .done(done), .fatal(fatal), .bound_o(bound_o), .attr_o(attr_o)
  );

  int         nvec = 0;
  int         nfail = 0;
  logic [7:0] mem [2][7];
  int         log_sf [64];
  int         nlog;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_sock(input int s, input int t, input int d, input int bk,
                          input int c, input int ac, input int col, input int w);
    mem[s][0] = 8'(t);  mem[s][1] = 8'(d);  mem[s][2] = 8'(bk);
    mem[s][3] = 8'(c);  mem[s][4] = 8'(ac); mem[s][5] = 8'(col);
    mem[s][6] = 8'(w);
  endtask

  // Expected per-socket result straight from the requirement text.
  function automatic void model(input int s, output int a, output int b,
                                output int code, output bit f);
    int den, bk, s1, s2, rest, mb1, mb2, kb, idx;
    longint p;
    a = 0; b = 0; code = 255; f = 1'b0;
    if (mem[s][0] != 8'd4) return;
    den = int'(mem[s][1]); bk = int'(mem[s][2]);
    s1 = 0;
    for (int i = 128; i > 0; i >>= 1) if ((den & i) != 0) begin s1 = i; break; end
    s2 = 0;
    if (bk > 1) begin
      rest = den & ~s1;
      if (rest == 0) s2 = s1;
      else begin
        for (int i = s1 >> 1; i > 0; i >>= 1) if ((rest & i) != 0) begin s2 = i; break; end
        if (s2 != s1) s2 = 0;
      end
    end
    mb1 = s1 * 4; mb2 = s2 * 4;
    if (mb1 < 32 || mb1 > 256 || mem[s][3] != 8'h75 || mem[s][4] != 8'h54) f = 1'b1;
    p = longint'(mem[s][6]) << mem[s][5];
    kb = int'(p >> 13);
    idx = -1;
    if (kb == 2) idx = 0; else if (kb == 4) idx = 1;
    else if (kb == 8) idx = 2; else if (kb == 16) idx = 3;
    if (idx < 0) f = 1'b1;
    if (bk == 1) code = 240 + idx;
    else if (bk == 2) code = idx * 17;
    else f = 1'b1;
    if (f) begin code = 255; return; end
    a = mb1 / 32; b = mb2 / 32;
  endfunction

  task automatic run_case(input int seed, input bit poke);
    int nreq, cyc, s, f;
    nreq = 0; nlog = 0; cyc = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 600) begin
      if (rq_valid) begin
        s = int'(rq_socket); f = int'(rq_field);
        if (nlog < 64) log_sf[nlog] = s * 8 + f;
        nlog++;
        repeat ((seed + nreq) % 3) @(negedge clk);
        rq_ready = 1'b1;
        if (poke && nreq == 2) start = 1'b1;
        @(negedge clk);
        rq_ready = 1'b0; start = 1'b0;
        repeat ((seed + 2 * nreq) % 3) @(negedge clk);
        rsp_valid = 1'b1; rsp_data = mem[s][f % 7];
        @(negedge clk);
        rsp_valid = 1'b0;
        nreq++;
        cyc += 6;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    chk(done == 1'b1, "R10", "done after decode", int'(done), 1);
  endtask

  task automatic check_outputs(input string tag);
    int a0, b0, c0, a1, b1, c1;
    bit f0, f1;
    int e [6];
    int exp_sf [14];
    int ne;
    bit ok;
    model(0, a0, b0, c0, f0);
    model(1, a1, b1, c1, f1);
    e[0] = a0; e[1] = a0 + b0; e[2] = e[1] + a1; e[3] = e[2] + b1;
    e[4] = e[3]; e[5] = e[3];
    chk(fatal == (f0 | f1), "R5", {tag, " fatal"}, int'(fatal), int'(f0 | f1));
    for (int i = 0; i < 6; i++)
      chk(int'(bound_o[i*8 +: 8]) == e[i], "R6", $sformatf("%s entry %0d", tag, i),
          int'(bound_o[i*8 +: 8]), e[i]);
    chk(int'(attr_o[7:0]) == c0, "R8", {tag, " attr s0"}, int'(attr_o[7:0]), c0);
    chk(int'(attr_o[15:8]) == c1, "R8", {tag, " attr s1"}, int'(attr_o[15:8]), c1);
    ne = 0;
    for (int s = 0; s < 2; s++) begin
      exp_sf[ne++] = s * 8;
      if (mem[s][0] == 8'd4) for (int f = 1; f < 7; f++) exp_sf[ne++] = s * 8 + f;
    end
    ok = (nlog == ne);
    for (int i = 0; i < ne && ok; i++) ok = (log_sf[i] == exp_sf[i]);
    chk(ok, "R2", {tag, " request order"}, nlog, ne);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  int widths [10] = '{0, 1, 8, 16, 18, 32, 64, 72, 128, 255};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b0 && fatal == 1'b0, "R1", "reset flags", {30'd0, done, fatal}, 0);
    chk(bound_o == 48'd0, "R1", "reset bounds", int'(bound_o[31:0]), 0);
    chk(attr_o == 16'hFFFF, "R1", "reset attr", int'(attr_o), 'hFFFF);
    chk(rq_valid == 1'b0, "R2", "idle no request", int'(rq_valid), 0);

    // R3 both absent
    set_sock(0, 0, 8'h10, 2, 8'h75, 8'h54, 9, 64);
    set_sock(1, 5, 8'h10, 2, 8'h75, 8'h54, 9, 64);
    run_case(0, 1'b0);
    check_outputs("R3 both absent");

    // R1 start clears results: fatal run first, then check cleared state
    set_sock(0, 4, 8'h01, 1, 8'h75, 8'h54, 9, 64);
    run_case(1, 1'b0);
    chk(fatal == 1'b1, "R9", "fatal set", int'(fatal), 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(fatal == 1'b0 && done == 1'b0, "R1", "start clears flags",
        {30'd0, done, fatal}, 0);
    chk(attr_o == 16'hFFFF && bound_o == 48'd0, "R1", "start clears map",
        int'(attr_o), 'hFFFF);
    while (!done) begin
      if (rq_valid) rq_ready = 1'b1;
      if (rsp_ready) begin rsp_valid = 1'b1; rsp_data = mem[rq_socket][rq_field]; end
      @(negedge clk);
      rq_ready = 1'b0; rsp_valid = 1'b0;
    end

    // R4 R5 R9 density sweep under both bank counts, faults mixed in
    for (int d = 0; d < 256; d++) begin
      for (int bk = 1; bk <= 2; bk++) begin
        set_sock(0, 4, d, bk, (d % 32 == 7) ? 8'h74 : 8'h75,
                 (d % 32 == 9) ? 8'h55 : 8'h54, 9, 64);
        set_sock(1, (d % 16 == 5) ? 0 : 4, (d * 37 + 11) & 255, 3 - bk,
                 8'h75, 8'h54, 8, 64);
        run_case(d + bk, (d % 8 == 3));
        check_outputs("R4 density sweep");
      end
    end

    // R7 R8 page-size grid
    for (int col = 0; col < 20; col++) begin
      for (int wi = 0; wi < 10; wi++) begin
        set_sock(0, 4, 8'h20, 1 + (col % 2), 8'h75, 8'h54, col, widths[wi]);
        set_sock(1, 4, 8'h08, 2 - (col % 2), 8'h75, 8'h54, col, widths[(wi + 3) % 10]);
        run_case(col + wi, 1'b0);
        check_outputs("R7 page grid");
      end
    end

    // R8 unsupported bank bytes
    for (int bk = 0; bk < 6; bk += 3) begin
      set_sock(0, 4, 8'h10, bk, 8'h75, 8'h54, 10, 16);
      set_sock(1, 4, 8'h40, 2, 8'h75, 8'h54, 10, 16);
      run_case(bk, 1'b0);
      check_outputs("R8 bank byte");
    end

    // R6 R10 largest map, then hold after done
    set_sock(0, 4, 8'h40, 2, 8'h75, 8'h54, 11, 64);
    set_sock(1, 4, 8'h40, 2, 8'h75, 8'h54, 11, 64);
    run_case(2, 1'b1);
    check_outputs("R6 max map");
    repeat (7) @(negedge clk);
    chk(done == 1'b1 && int'(bound_o[47:40]) == 32, "R10", "hold after done",
        int'(bound_o[47:40]), 32);
    chk(attr_o == 16'h3333, "R10", "attr hold", int'(attr_o), 'h3333);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule